// File: doc/BRIEF.md
# Predicated Instruction Control Decoder

This block is the purely combinational control unit of a small 16-bit processor. Each cycle it takes the instruction word being executed and the zero flag held in the processor's flag register. From these it produces every control strobe the datapath needs: the register write enable, the memory write enable, the flag register update enable, the ALU operation, and which source feeds the register write-back port.

Any instruction can be predicated. A single condition bit in the word asks whether the instruction should run only when the stored zero flag is set. The decoder folds this test into one execute decision, which it also drives on a status output. That decision masks every strobe that changes state, so a skipped instruction leaves the register file, memory and flags untouched.

The register selectors and the 8-bit immediate are split out of the word unchanged for the datapath. Operand muxing, the ALU, the program counter and memory all sit outside this block.

Top module: `ctl_decoder`

## Requirements
- R1: Field outputs copy the word without change. `rd_o` is bits 10:8, `ra_o` is bits 6:4, `rb_o` is bits 2:0 and `imm_o` is bits 7:0, for every opcode and every condition value.
- R2: `exec_o` is 1 when the condition bit (bit 11) is 0. When that bit is 1, `exec_o` is 1 exactly when `z_flag_i` is 1.
- R3: Opcode 0000 (load immediate low) with `exec_o`=1 gives `reg_we_o`=1 and `wb_sel_o`=2 (immediate, zero-extended), with `mem_we_o`=0 and `flag_en_o`=0.
- R4: Opcode 0001 (set high byte) with `exec_o`=1 gives `reg_we_o`=1 and `wb_sel_o`=3 (immediate into the upper byte, lower byte kept), with `mem_we_o`=0 and `flag_en_o`=0.
- R5: Opcode 0100 (store rd to address ra) with `exec_o`=1 gives `mem_we_o`=1, `reg_we_o`=0 and `flag_en_o`=0. No other opcode ever raises `mem_we_o`.
- R6: Opcode 0101 (load from address ra into rd) with `exec_o`=1 gives `reg_we_o`=1 and `wb_sel_o`=1 (memory), with `mem_we_o`=0 and `flag_en_o`=0.
- R7: Opcodes 1000 add, 1001 subtract, 1010 and, 1011 exclusive-or with `exec_o`=1 give `reg_we_o`=1, `flag_en_o`=1 and `wb_sel_o`=0 (ALU). `alu_op_o` equals the low two opcode bits (0 add, 1 sub, 2 and, 3 xor). `flag_en_o` is never 1 for any other opcode.
- R8: When the condition bit is 1 and `z_flag_i` is 0, `reg_we_o`, `mem_we_o` and `flag_en_o` are all 0, whatever the opcode.
- R9: The opcodes 0010, 0011, 0110, 0111 and 1100 to 1111 raise none of `reg_we_o`, `mem_we_o` or `flag_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word being executed |
| z_flag_i | input | 1 | Stored zero flag from the flag register |
| reg_we_o | output | 1 | Register file write enable for rd |
| mem_we_o | output | 1 | Data memory write enable |
| flag_en_o | output | 1 | Flag register update enable |
| alu_op_o | output | 2 | ALU function: 0 add, 1 sub, 2 and, 3 xor |
| wb_sel_o | output | 2 | Write-back source: 0 ALU, 1 memory, 2 immediate low, 3 immediate high |
| exec_o | output | 1 | Execute decision for the current instruction |
| rd_o | output | 3 | Destination register selector |
| ra_o | output | 3 | First source / address register selector |
| rb_o | output | 3 | Second source register selector |
| imm_o | output | 8 | Immediate byte |

## Verification
All sixteen opcodes are swept across the four combinations of condition bit and zero flag. This tells apart an always-run instruction, a predicated one that runs, and a predicated one that is skipped. It also shows that the zero flag has no effect when the condition bit is clear. Each combination is repeated with operand fields of all zeros, all ones and two alternating patterns. These expose a swapped or shifted field slice, and any decode that wrongly depends on operand bits rather than the opcode. The unassigned opcodes take part in the same sweep, so a stray strobe on them is caught just like one on a skipped instruction.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int unsigned OP_W = 4;

  localparam logic [OP_W-1:0] OP_MOVL = 4'b0000;
  localparam logic [OP_W-1:0] OP_SETH = 4'b0001;
  localparam logic [OP_W-1:0] OP_STR  = 4'b0100;
  localparam logic [OP_W-1:0] OP_LDR  = 4'b0101;
  localparam logic [OP_W-1:0] OP_ADD  = 4'b1000;
  localparam logic [OP_W-1:0] OP_SUB  = 4'b1001;
  localparam logic [OP_W-1:0] OP_AND  = 4'b1010;
  localparam logic [OP_W-1:0] OP_XOR  = 4'b1011;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_XOR = 2'd3
  } alu_op_e;

  typedef enum logic [1:0] {
    WB_ALU    = 2'd0,
    WB_MEM    = 2'd1,
    WB_IMM_LO = 2'd2,
    WB_IMM_HI = 2'd3
  } wb_sel_e;

  typedef struct packed {
    logic    reg_we;
    logic    mem_we;
    logic    flag_en;
    alu_op_e alu_op;
    wb_sel_e wb_sel;
  } ctl_t;
endpackage

// File: rtl/ctl_field_split.sv
module ctl_field_split
  import ctl_pkg::*;
#(
  parameter int unsigned RSEL_W  = 3,
  parameter int unsigned IMM_W   = 8,
  localparam int unsigned INSTR_W = OP_W + 1 + RSEL_W + IMM_W,
  localparam int unsigned OP_LSB  = INSTR_W - OP_W,
  localparam int unsigned CND_BIT = OP_LSB - 1,
  localparam int unsigned RD_LSB  = CND_BIT - RSEL_W,
  localparam int unsigned RA_LSB  = IMM_W / 2
) (
  input  logic [INSTR_W-1:0] instr_i,
  output logic [OP_W-1:0]    op_o,
  output logic               cond_o,
  output logic [RSEL_W-1:0]  rd_o,
  output logic [RSEL_W-1:0]  ra_o,
  output logic [RSEL_W-1:0]  rb_o,
  output logic [IMM_W-1:0]   imm_o
);
  assign op_o   = instr_i[OP_LSB +: OP_W];
  assign cond_o = instr_i[CND_BIT];
  assign rd_o   = instr_i[RD_LSB +: RSEL_W];
  assign ra_o   = instr_i[RA_LSB +: RSEL_W];
  assign rb_o   = instr_i[0 +: RSEL_W];
  assign imm_o  = instr_i[0 +: IMM_W];
endmodule

// File: rtl/ctl_op_decode.sv
module ctl_op_decode
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctl_t            raw_o
);
  always_comb begin
    raw_o = '{reg_we: 1'b0, mem_we: 1'b0, flag_en: 1'b0,
              alu_op: ALU_ADD, wb_sel: WB_ALU};
    unique case (op_i)
      OP_MOVL: begin
        raw_o.reg_we = 1'b1;
        raw_o.wb_sel = WB_IMM_LO;
      end
      OP_SETH: begin
        raw_o.reg_we = 1'b1;
        raw_o.wb_sel = WB_IMM_HI;
      end
      OP_STR: raw_o.mem_we = 1'b1;
      OP_LDR: begin
        raw_o.reg_we = 1'b1;
        raw_o.wb_sel = WB_MEM;
      end
      OP_ADD, OP_SUB, OP_AND, OP_XOR: begin
        raw_o.reg_we  = 1'b1;
        raw_o.flag_en = 1'b1;
        raw_o.alu_op  = alu_op_e'(op_i[1:0]);
      end
      default: ;  // unassigned: no side effects
    endcase
  end
endmodule

// File: rtl/ctl_exec_gate.sv
module ctl_exec_gate
  import ctl_pkg::*;
(
  input  logic cond_i,
  input  logic z_flag_i,
  input  ctl_t raw_i,
  output ctl_t gated_o,
  output logic exec_o
);
  logic exec;
  assign exec   = ~cond_i | z_flag_i;
  assign exec_o = exec;

  // selects pass through; only state-changing strobes are masked
  always_comb begin
    gated_o         = raw_i;
    gated_o.reg_we  = raw_i.reg_we  & exec;
    gated_o.mem_we  = raw_i.mem_we  & exec;
    gated_o.flag_en = raw_i.flag_en & exec;
  end
endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
  import ctl_pkg::*;
#(
  parameter int unsigned RSEL_W  = 3,
  parameter int unsigned IMM_W   = 8,
  localparam int unsigned INSTR_W = OP_W + 1 + RSEL_W + IMM_W
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               z_flag_i,
  output logic               reg_we_o,
  output logic               mem_we_o,
  output logic               flag_en_o,
  output logic [1:0]         alu_op_o,
  output logic [1:0]         wb_sel_o,
  output logic               exec_o,
  output logic [RSEL_W-1:0]  rd_o,
  output logic [RSEL_W-1:0]  ra_o,
  output logic [RSEL_W-1:0]  rb_o,
  output logic [IMM_W-1:0]   imm_o
);
  logic [OP_W-1:0] op;
  logic            cond;
  ctl_t            raw;
  ctl_t            gated;

  ctl_field_split #(.RSEL_W(RSEL_W), .IMM_W(IMM_W)) u_split (
    .instr_i (instr_i),
    .op_o    (op),
    .cond_o  (cond),
    .rd_o    (rd_o),
    .ra_o    (ra_o),
    .rb_o    (rb_o),
    .imm_o   (imm_o)
  );

  ctl_op_decode u_dec (
    .op_i  (op),
    .raw_o (raw)
  );

  ctl_exec_gate u_gate (
    .cond_i   (cond),
    .z_flag_i (z_flag_i),
    .raw_i    (raw),
    .gated_o  (gated),
    .exec_o   (exec_o)
  );

  assign reg_we_o  = gated.reg_we;
  assign mem_we_o  = gated.mem_we;
  assign flag_en_o = gated.flag_en;
  assign alu_op_o  = gated.alu_op;
  assign wb_sel_o  = gated.wb_sel;
endmodule

// File: rtl/ctl_decoder_chk.sv
module ctl_decoder_chk #(
  parameter int unsigned RSEL_W  = 3,
  parameter int unsigned IMM_W   = 8,
  localparam int unsigned INSTR_W = 4 + 1 + RSEL_W + IMM_W
) (
  input logic [INSTR_W-1:0] instr_i,
  input logic               z_flag_i,
  input logic               reg_we_o,
  input logic               mem_we_o,
  input logic               flag_en_o,
  input logic [1:0]         wb_sel_o,
  input logic               exec_o,
  input logic [RSEL_W-1:0]  rd_o
);
  logic       cnd;
  logic [3:0] opc;
  assign cnd = instr_i[INSTR_W-5];
  assign opc = instr_i[INSTR_W-1 -: 4];

  always_comb begin
    if (!$isunknown({instr_i, z_flag_i})) begin
      p_uncond_runs_r2: assert (cnd || exec_o);
      p_skip_silent_r8: assert (!(cnd && !z_flag_i) ||
                                !(reg_we_o || mem_we_o || flag_en_o));
      p_mem_only_store_r5: assert (!mem_we_o || (opc == 4'b0100 && !reg_we_o));
      p_flag_alu_only_r7: assert (!flag_en_o ||
                                  (opc[3:2] == 2'b10 && reg_we_o && wb_sel_o == 2'd0));
      p_one_write_kind_r5: assert ($onehot0({reg_we_o, mem_we_o}));
      p_rd_slice_r1: assert (rd_o == instr_i[INSTR_W-6 -: RSEL_W]);
      p_hole_quiet_r9: assert (!(opc == 4'b0010 || opc == 4'b0011 ||
                                 opc == 4'b0110 || opc == 4'b0111 || opc[3:2] == 2'b11)
                               || !(reg_we_o || mem_we_o || flag_en_o));
    end
  end
endmodule

bind ctl_decoder ctl_decoder_chk #(.RSEL_W(RSEL_W), .IMM_W(IMM_W)) u_chk (
  .instr_i   (instr_i),
  .z_flag_i  (z_flag_i),
  .reg_we_o  (reg_we_o),
  .mem_we_o  (mem_we_o),
  .flag_en_o (flag_en_o),
  .wb_sel_o  (wb_sel_o),
  .exec_o    (exec_o),
  .rd_o      (rd_o)
);

// File: tb/tb_ctl_decoder.sv
module tb_ctl_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr = '0;
  logic        zf = 1'b0;
  logic        reg_we, mem_we, flag_en, exec;
  logic [1:0]  alu_op, wb_sel;
  logic [2:0]  rd, ra, rb;
  logic [7:0]  imm;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [15:0] ins;
    logic        z;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_decoder dut (
    .instr_i (instr), .z_flag_i (zf),
    .reg_we_o (reg_we), .mem_we_o (mem_we), .flag_en_o (flag_en),
    .alu_op_o (alu_op), .wb_sel_o (wb_sel), .exec_o (exec),
    .rd_o (rd), .ra_o (ra), .rb_o (rb), .imm_o (imm)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d instr=%h z=%0b", req, act, exp, instr, zf);
    end
  endtask

  task automatic drive(input logic [15:0] ins, input logic z);
    @(posedge clk);
    #1;
    instr = ins;
    zf    = z;
    sb_q.push_back('{ins: ins, z: z});
  endtask

  // monitor: compare against requirement model
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [3:0] op;
      logic e_exec, e_rwe, e_mwe, e_fen;
      int e_wb;
      string tag;
      it = sb_q.pop_front();
      op = it.ins[15:12];
      e_exec = !it.ins[11] || it.z;
      e_rwe = 0; e_mwe = 0; e_fen = 0; e_wb = -1; tag = "R9";
      case (op)
        4'b0000: begin tag = "R3"; e_rwe = e_exec; e_wb = 2; end
        4'b0001: begin tag = "R4"; e_rwe = e_exec; e_wb = 3; end
        4'b0100: begin tag = "R5"; e_mwe = e_exec; end
        4'b0101: begin tag = "R6"; e_rwe = e_exec; e_wb = 1; end
        4'b1000, 4'b1001, 4'b1010, 4'b1011: begin
          tag = "R7"; e_rwe = e_exec; e_fen = e_exec; e_wb = 0;
          chk("R7 alu_op", int'(alu_op), int'(op[1:0]));
        end
        default: ;
      endcase
      if (!e_exec) tag = "R8";
      chk("R2 exec", int'(exec), int'(e_exec));
      chk({tag, " reg_we"}, int'(reg_we), int'(e_rwe));
      chk({tag, " mem_we"}, int'(mem_we), int'(e_mwe));
      chk({tag, " flag_en"}, int'(flag_en), int'(e_fen));
      if (e_rwe) chk({tag, " wb_sel"}, int'(wb_sel), e_wb);
      chk("R1 rd", int'(rd), int'(it.ins[10:8]));
      chk("R1 ra", int'(ra), int'(it.ins[6:4]));
      chk("R1 rb", int'(rb), int'(it.ins[2:0]));
      chk("R1 imm", int'(imm), int'(it.ins[7:0]));
    end
  end

  initial begin
    logic [10:0] pats [4];
    pats[0] = 11'h000; pats[1] = 11'h7FF; pats[2] = 11'h5A5; pats[3] = 11'h2D3;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset state: all-zero word is an unconditional load of zero
    drive(16'h0000, 1'b0);
    for (int p = 0; p < 4; p++)
      for (int o = 0; o < 16; o++)
        for (int c = 0; c < 2; c++)
          for (int z = 0; z < 2; z++)
            drive({o[3:0], c[0], pats[p]}, z[0]);
    // predicated store skipped, then taken (R8, R5)
    drive(16'h4B30, 1'b0);
    drive(16'h4B30, 1'b1);
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WDOG_LIMIT) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, WDOG_LIMIT);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule